// File: doc/BRIEF.md
# Event Timestamp Capture Unit

This block is the front end of a time-stamping logic analyzer. It does not sample the input pins at a fixed rate. It records data only when the watched pins change.

On every qualifying change it takes two values at the same clock edge: the pin pattern and the value of a free-running timebase. It then sends these two values as a pair of words on a valid/ready stream. The pattern word comes first and the timestamp word second. After the pair it waits for the next change. This keeps quiet periods cheap and gives a wide dynamic range with single-clock resolution.

A small queue of pairs sits between capture and output, so short stalls on the output side do not lose events. If the queue is full, the newest event is dropped and a sticky flag records the loss. The unit has two capture modes:

- **Continuous mode:** every qualifying change is recorded.
- **One-shot mode:** only the first qualifying change after an arm pulse is recorded, and then the unit must be armed again.

Top module: `etc_capture_top`

## Requirements
- R1: While `rst` is high and after it falls, `out_valid` and `overflow` are 0. The pin level present when reset ends is not treated as a change, so held pins produce no output.
- R2: An event is a difference in at least one pin whose `pin_mask` bit is 1, comparing the pins with their value one clock earlier. Changes on pins whose mask bit is 0 produce no output.
- R3: Each captured event leaves the output as exactly two words:
  - The first word is the pin pattern, zero-extended to `DATA_W`, with `out_last` = 0.
  - The second word is the timestamp, zero-extended, with `out_last` = 1.
- R4: The timebase is 0 while `rst` is high and advances by one on every clock edge after that. The timestamp of an event is the timebase value in the clock cycle in which the changed pattern is present on `pins`, which gives one-clock resolution.
- R5: A word moves only on a clock edge with `out_valid` and `out_ready` both high. While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold their values.
- R6: With `out_ready` held high, events spaced two clocks apart are all delivered in order, and `overflow` stays 0.
- R7: With `one_shot` = 1, events are accepted only after a one-cycle `arm` pulse, and only the first event after it is captured. An `arm` in the same cycle as the event counts. Later events produce no output until the next `arm`.
- R8: With `one_shot` = 0, every event is captured whether or not `arm` is pulsed.
- R9: The unit holds at most `FIFO_DEPTH`+1 undelivered pairs: `FIFO_DEPTH` queued plus one at the output. If an accepted event arrives while `FIFO_DEPTH` pairs are queued:
  - that event is dropped;
  - `overflow` goes to 1 and stays 1 until reset;
  - the earlier pairs are still delivered intact.
- R10: The timebase wraps modulo 2^`TS_W`, so a timestamp equals the number of edges since reset modulo 2^`TS_W`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pins | input | PIN_W | Watched input pattern, already synchronous to `clk` |
| pin_mask | input | PIN_W | Per-pin enable for change detection (1 = watched) |
| one_shot | input | 1 | 1 selects one-shot capture, 0 selects continuous capture |
| arm | input | 1 | Single-cycle pulse that arms one-shot capture |
| out_ready | input | 1 | Downstream accepts a word |
| out_valid | output | 1 | A word is presented on `out_data` |
| out_data | output | DATA_W | Pattern word or timestamp word |
| out_last | output | 1 | 1 on the timestamp word of a pair |
| overflow | output | 1 | Sticky flag: an event was dropped because the queue was full |

## Verification
The bench builds the unit with an 8-bit pin group, an 8-bit timebase, 16-bit output words and a two-entry queue. The narrow timebase wraps after 256 clocks, so a wrapped timestamp (R10) is reached in a short run. The shallow queue fills after three stalled events, which makes the drop-and-flag path and the `FIFO_DEPTH`+1 capacity limit quick to exercise. The 16-bit words also show that patterns and timestamps are zero-extended to the output width.

// File: rtl/etc_pkg.sv
package etc_pkg;

  // Which half of a captured pair the output stage is presenting.
  typedef enum logic {
    PH_PAT = 1'b0,
    PH_TS  = 1'b1
  } word_phase_t;

endpackage

// File: rtl/etc_event_detect.sv
// Change detection, free-running timebase and one-shot arming.
module etc_event_detect #(
  parameter int PIN_W = 32,
  parameter int TS_W  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PIN_W-1:0] pins,
  input  logic [PIN_W-1:0] pin_mask,
  input  logic             one_shot,
  input  logic             arm,
  output logic             ev_fire,
  output logic [PIN_W-1:0] ev_pat,
  output logic [TS_W-1:0]  ev_ts
);

  logic [PIN_W-1:0] pin_q;
  logic [PIN_W-1:0] chg;
  logic [TS_W-1:0]  tbase_q;
  logic             armed_q;
  logic             raw_ev;
  logic             accept;

  // One change flag per pin, gated by its own mask bit.
  for (genvar i = 0; i < PIN_W; i++) begin : g_chg
    assign chg[i] = pin_mask[i] & (pins[i] ^ pin_q[i]);
  end

  assign raw_ev  = |chg;
  assign accept  = ~one_shot | armed_q | arm;
  assign ev_fire = raw_ev & accept;
  assign ev_pat  = pins;
  assign ev_ts   = tbase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      // Load the live pattern so that the level at reset release is not a change.
      pin_q   <= pins;
      tbase_q <= '0;
      armed_q <= 1'b0;
    end else begin
      pin_q   <= pins;
      tbase_q <= tbase_q + 1'b1;
      if (one_shot && ev_fire)
        armed_q <= 1'b0;
      else if (one_shot && arm)
        armed_q <= 1'b1;
    end
  end

endmodule

// File: rtl/etc_pair_fifo.sv
// Queue of captured pairs; synchronous write into a plain array.
module etc_pair_fifo #(
  parameter int W     = 64,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] pop_data,
  output logic         full,
  output logic         empty
);

  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wr_ptr;
  logic [AW:0]  rd_ptr;

  assign empty    = (wr_ptr == rd_ptr);
  assign full     = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
  assign pop_data = mem[rd_ptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (push)
      mem[wr_ptr[AW-1:0]] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
    end
  end

endmodule

// File: rtl/etc_serializer.sv
// Presents one pair as two words on a registered valid/ready stream.
module etc_serializer
  import etc_pkg::*;
#(
  parameter int PIN_W  = 32,
  parameter int TS_W   = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              avail,
  input  logic [PIN_W-1:0]  in_pat,
  input  logic [TS_W-1:0]   in_ts,
  output logic              pop,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last
);

  logic              valid_q;
  word_phase_t       phase_q;
  logic [DATA_W-1:0] data_q;
  logic [TS_W-1:0]   hold_ts_q;
  logic              take;
  logic              free;

  assign take = valid_q & out_ready;
  // The stage can load a new pair once the timestamp word leaves, in the same edge.
  assign free = ~valid_q | (take & (phase_q == PH_TS));
  assign pop  = free & avail;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q   <= 1'b0;
      phase_q   <= PH_PAT;
      data_q    <= '0;
      hold_ts_q <= '0;
    end else if (pop) begin
      valid_q   <= 1'b1;
      phase_q   <= PH_PAT;
      data_q    <= DATA_W'(in_pat);
      hold_ts_q <= in_ts;
    end else if (take) begin
      if (phase_q == PH_PAT) begin
        phase_q <= PH_TS;
        data_q  <= DATA_W'(hold_ts_q);
      end else begin
        valid_q <= 1'b0;
        phase_q <= PH_PAT;
      end
    end
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;
  assign out_last  = (phase_q == PH_TS);

endmodule

// File: rtl/etc_capture_top.sv
module etc_capture_top #(
  parameter int PIN_W      = 32,
  parameter int TS_W       = 32,
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PIN_W-1:0]  pins,
  input  logic [PIN_W-1:0]  pin_mask,
  input  logic              one_shot,
  input  logic              arm,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  output logic              overflow
);

  localparam int ENTRY_W = PIN_W + TS_W;

  logic               ev_fire;
  logic [PIN_W-1:0]   ev_pat;
  logic [TS_W-1:0]    ev_ts;
  logic               fifo_full;
  logic               fifo_empty;
  logic               fifo_push;
  logic               fifo_pop;
  logic [ENTRY_W-1:0] fifo_rd;
  logic               ovf_q;

  etc_event_detect #(.PIN_W(PIN_W), .TS_W(TS_W)) u_detect (
    .clk      (clk),
    .rst      (rst),
    .pins     (pins),
    .pin_mask (pin_mask),
    .one_shot (one_shot),
    .arm      (arm),
    .ev_fire  (ev_fire),
    .ev_pat   (ev_pat),
    .ev_ts    (ev_ts)
  );

  assign fifo_push = ev_fire & ~fifo_full;

  etc_pair_fifo #(.W(ENTRY_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push      (fifo_push),
    .push_data ({ev_pat, ev_ts}),
    .pop       (fifo_pop),
    .pop_data  (fifo_rd),
    .full      (fifo_full),
    .empty     (fifo_empty)
  );

  etc_serializer #(.PIN_W(PIN_W), .TS_W(TS_W), .DATA_W(DATA_W)) u_ser (
    .clk       (clk),
    .rst       (rst),
    .avail     (~fifo_empty),
    .in_pat    (fifo_rd[ENTRY_W-1:TS_W]),
    .in_ts     (fifo_rd[TS_W-1:0]),
    .pop       (fifo_pop),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_last  (out_last)
  );

  always_ff @(posedge clk) begin
    if (rst)
      ovf_q <= 1'b0;
    else if (ev_fire && fifo_full)
      ovf_q <= 1'b1;
  end

  assign overflow = ovf_q;

endmodule

// File: rtl/etc_capture_chk.sv
module etc_capture_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              out_ready,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic              out_last,
  input logic              overflow,
  input logic              ev_fire,
  input logic              fifo_full
);

  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R5

  AST_TS_FOLLOWS_PAT: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !out_last) |=> (out_valid && out_last)); // R3

  AST_PAT_AFTER_TS: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_last) |=> (!out_valid || !out_last)); // R3

  AST_DROP_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    (ev_fire && fifo_full) |=> overflow); // R9

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow); // R9

endmodule

bind etc_capture_top etc_capture_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .out_ready (out_ready),
  .out_valid (out_valid),
  .out_data  (out_data),
  .out_last  (out_last),
  .overflow  (overflow),
  .ev_fire   (ev_fire),
  .fifo_full (fifo_full)
);

// File: tb/tb_etc_capture_top.sv
`timescale 1ns/1ps
module tb_etc_capture_top;

  localparam int PIN_W  = 8;
  localparam int TS_W   = 8;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [PIN_W-1:0]  pins = '0;
  logic [PIN_W-1:0]  pin_mask = '1;
  logic              one_shot = 1'b0;
  logic              arm = 1'b0;
  logic              out_ready = 1'b1;
  logic              out_valid;
  logic [DATA_W-1:0] out_data;
  logic              out_last;
  logic              overflow;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [DATA_W:0] rx [$];

  always #5 clk = ~clk;

  etc_capture_top #(.PIN_W(PIN_W), .TS_W(TS_W), .DATA_W(DATA_W), .FIFO_DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .pins(pins), .pin_mask(pin_mask), .one_shot(one_shot),
    .arm(arm), .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .out_last(out_last), .overflow(overflow)
  );

  // Reference edge count since reset (requirement R4).
  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  // Collect every transferred word; the transfer happens at the following edge.
  always @(negedge clk) begin
    if (!rst && out_valid && out_ready)
      rx.push_back({out_last, out_data});
  end

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic expect_pair(string req, logic [PIN_W-1:0] pat, int ts);
    logic [DATA_W:0] w0;
    logic [DATA_W:0] w1;
    for (int i = 0; i < 40 && rx.size() < 2; i++) step();
    if (rx.size() < 2) begin
      check({req, " pair missing"}, 32'(rx.size()), 32'd2);
      return;
    end
    w0 = rx.pop_front();
    w1 = rx.pop_front();
    check({req, " pattern word"}, 32'(w0), 32'({1'b0, DATA_W'(pat)}));
    check({req, " timestamp word"}, 32'(w1), 32'({1'b1, DATA_W'(ts % (1 << TS_W))}));
  endtask

  task automatic expect_none(string req, int n);
    for (int i = 0; i < n; i++) step();
    check({req, " no output"}, 32'(rx.size()), 32'd0);
    rx.delete();
  endtask

  task automatic t_reset();
    pins = 8'hA5;
    rst = 1'b1;
    repeat (3) step();
    check("R1 valid in reset", 32'(out_valid), 32'd0);
    check("R1 overflow in reset", 32'(overflow), 32'd0);
    rst = 1'b0;
    step();
    check("R1 valid after reset", 32'(out_valid), 32'd0);
    expect_none("R1 held pins", 8);
    check("R1 overflow after reset", 32'(overflow), 32'd0);
  endtask

  task automatic t_basic();
    int ts;
    pins = 8'h3C; ts = cyc;
    expect_pair("R3 R4 single event", 8'h3C, ts);
    step(); step();
    pins = 8'hC3; ts = cyc;
    expect_pair("R3 R4 second event", 8'hC3, ts);
  endtask

  task automatic t_mask();
    int ts;
    pin_mask = 8'h0F;
    step();
    pins = 8'h43;
    expect_none("R2 masked change", 8);
    pins = 8'h42; ts = cyc;
    expect_pair("R2 watched change", 8'h42, ts);
    pin_mask = 8'hFF;
  endtask

  task automatic t_burst();
    int t0, t1, t2, t3;
    step();
    pins = 8'h01; t0 = cyc; step(); step();
    pins = 8'h02; t1 = cyc; step(); step();
    pins = 8'h04; t2 = cyc; step(); step();
    pins = 8'h08; t3 = cyc;
    expect_pair("R6 burst 0", 8'h01, t0);
    expect_pair("R6 burst 1", 8'h02, t1);
    expect_pair("R6 burst 2", 8'h04, t2);
    expect_pair("R6 burst 3", 8'h08, t3);
    check("R6 no overflow", 32'(overflow), 32'd0);
  endtask

  task automatic t_stall();
    int ts;
    logic [DATA_W-1:0] held;
    out_ready = 1'b0;
    step();
    pins = 8'h77; ts = cyc;
    repeat (4) step();
    @(negedge clk);
    check("R5 valid while stalled", 32'(out_valid), 32'd1);
    check("R5 pattern presented", 32'(out_data), 32'h0077);
    held = out_data;
    step(); step();
    @(negedge clk);
    check("R5 data held", 32'(out_data), 32'(held));
    check("R5 last held", 32'(out_last), 32'd0);
    step();
    out_ready = 1'b1;
    expect_pair("R5 after release", 8'h77, ts);
  endtask

  task automatic t_oneshot();
    int ts;
    one_shot = 1'b1;
    step();
    pins = 8'h11;
    expect_none("R7 unarmed", 8);
    arm = 1'b1; step(); arm = 1'b0;
    step();
    pins = 8'h12; ts = cyc; step(); step();
    pins = 8'h13;
    expect_pair("R7 first after arm", 8'h12, ts);
    expect_none("R7 second ignored", 8);
    arm = 1'b1; pins = 8'h14; ts = cyc;
    step(); arm = 1'b0;
    expect_pair("R7 arm same cycle", 8'h14, ts);
    one_shot = 1'b0;
  endtask

  task automatic t_cont();
    int t0, t1;
    step();
    arm = 1'b1; step(); arm = 1'b0;
    pins = 8'h21; t0 = cyc; step(); step(); step();
    pins = 8'h22; t1 = cyc;
    expect_pair("R8 continuous 0", 8'h21, t0);
    expect_pair("R8 continuous 1", 8'h22, t1);
  endtask

  task automatic t_wrap();
    int ts;
    while (!(cyc > 256 && (cyc % 256) == 5)) step();
    pins = 8'h5A; ts = cyc;
    expect_pair("R10 wrapped timestamp", 8'h5A, 5);
    check("R10 ref count past wrap", 32'(ts > 256), 32'd1);
  endtask

  task automatic t_overflow();
    int t0, t1, t2;
    out_ready = 1'b0;
    step();
    pins = 8'h81; t0 = cyc; step(); step();
    pins = 8'h82; t1 = cyc; step(); step();
    pins = 8'h84; t2 = cyc; step(); step();
    check("R9 no flag at capacity", 32'(overflow), 32'd0);
    pins = 8'h88; step(); step();
    check("R9 flag on drop", 32'(overflow), 32'd1);
    out_ready = 1'b1;
    expect_pair("R9 kept 0", 8'h81, t0);
    expect_pair("R9 kept 1", 8'h82, t1);
    expect_pair("R9 kept 2", 8'h84, t2);
    expect_none("R9 dropped event", 10);
    check("R9 flag sticky", 32'(overflow), 32'd1);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_mask();
    t_burst();
    t_stall();
    t_oneshot();
    t_cont();
    t_wrap();
    t_overflow();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1500000;
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule